// File: doc/BRIEF.md
# CAN Data Frame Serializer

This block turns one CAN data or remote frame description into a serial bit stream, one bit per bit-time strobe. A frame is loaded with a single-cycle start request while the block is idle. The request carries an identifier, a format flag (11-bit base or 29-bit extended), a remote flag, a 4-bit length code and up to eight payload bytes. The block copies all of these fields into its own registers, so the caller may change its inputs while a frame is in flight.

The block steps through the frame fields in order. It computes the 15-bit CRC as the covered bits go out and appends it. It then sends the fixed-form tail. A companion flag marks the bits that a downstream bit stuffer must process. During the acknowledge slot the block samples the bus level and keeps it, and it pulses a done flag after the last end-of-frame bit. Bit timing, stuffing, arbitration and error handling belong to neighbouring blocks.

Top module: `can_frame_serializer`

## Requirements
- R1: Out of reset and whenever idle, `bit_o` is 1 (recessive), `stuff_en_o`, `busy_o`, `done_o` and `ack_received_o` are 0.
- R2: A `start_i` seen while idle latches all frame inputs. In the next cycle `busy_o` is 1 and `bit_o` shows the start-of-frame bit 0. `start_i` and input changes while busy have no effect on the frame being sent.
- R3: The bit on `bit_o` holds until a cycle with `bit_stb_i` high. The next frame bit appears in the following cycle.
- R4: Base format (`ext_i`=0): `id_i[28:18]` MSB first, then RTR (equal to `rtr_i`, 1 = remote), IDE=0, r0=0, then `dlc_i` MSB first.
- R5: Extended format (`ext_i`=1): `id_i[28:18]` MSB first, SRR=1, IDE=1, `id_i[17:0]` MSB first, RTR=`rtr_i`, r1=0, r0=0, then `dlc_i` MSB first.
- R6: The payload count is min(`dlc_i`, 8) for a data frame and 0 for a remote frame. Byte k is `data_i[8k+7:8k]`, sent in rising k, each MSB first.
- R7: After the payload come 15 CRC bits, MSB first. The CRC uses generator 0x4599 with a zero start value, applied over the start bit through the last payload bit. A CRC delimiter of 1 follows.
- R8: After the CRC delimiter the block sends ACK slot 1, ACK delimiter 1 and seven end-of-frame bits of 1.
- R9: `stuff_en_o` is 1 from the start bit through the last CRC bit and 0 for every later bit.
- R10: `ack_received_o` clears when a start is accepted. It is set to 1 in the cycle after the ACK-slot strobe if `bus_rx_i` was 0 at that strobe, and otherwise stays 0 until the next accepted start. `bus_rx_i` is ignored in every other bit.
- R11: `done_o` is a one-cycle pulse in the cycle after the strobe of the last end-of-frame bit. `busy_o` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, accepted only when idle |
| ext_i | input | 1 | 1 = 29-bit identifier format |
| rtr_i | input | 1 | 1 = remote frame |
| id_i | input | 29 | Identifier; base part in [28:18] |
| dlc_i | input | 4 | Length code |
| data_i | input | 64 | Payload, byte k in [8k+7:8k] |
| bit_stb_i | input | 1 | Bit-time strobe; the current bit is complete |
| bus_rx_i | input | 1 | Sampled bus level |
| bit_o | output | 1 | Current frame bit (0 = dominant) |
| stuff_en_o | output | 1 | Current bit lies in the stuffed region |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame finished pulse |
| ack_received_o | output | 1 | Dominant level seen in ACK slot |

## Verification
Every output is a register or is decoded from registers, so each result is due exactly one clock after the event that causes it:
- The start-of-frame bit and `busy_o` follow one cycle after an accepted start.
- Each later bit follows one cycle after its strobe.
- `ack_received_o` updates one cycle after the ACK-slot strobe.
- `done_o` pulses, and `busy_o` falls, one cycle after the final strobe.

The bench drives all inputs on the falling edge and pulses the strobe for one cycle. It then samples on the next falling edge, which falls between the edge that acts on the strobe and the next one. A quiet cycle after every strobe lets the bench confirm that `done_o` lasts one cycle and that the bus returns to recessive.

// File: rtl/can_ser_pkg.sv
package can_ser_pkg;
  localparam int BASE_W = 11;
  localparam int EXT_W  = 18;
  localparam int ID_W   = BASE_W + EXT_W;
  localparam int DLC_W  = 4;
  localparam int CRC_W  = 15;

  typedef enum logic [3:0] {
    F_IDLE, F_SOF, F_BASE, F_SRR, F_IDE, F_EXTID, F_RTR, F_R1, F_R0,
    F_DLC, F_DATA, F_CRC, F_CRCDEL, F_ACK, F_ACKDEL, F_EOF
  } field_e;

  function automatic field_e next_field(field_e f, logic ext, logic no_data);
    case (f)
      F_SOF:    return F_BASE;
      F_BASE:   return ext ? F_SRR : F_RTR;
      F_SRR:    return F_IDE;
      F_IDE:    return ext ? F_EXTID : F_R0;
      F_EXTID:  return F_RTR;
      F_RTR:    return ext ? F_R1 : F_IDE;
      F_R1:     return F_R0;
      F_R0:     return F_DLC;
      F_DLC:    return no_data ? F_CRC : F_DATA;
      F_DATA:   return F_CRC;
      F_CRC:    return F_CRCDEL;
      F_CRCDEL: return F_ACK;
      F_ACK:    return F_ACKDEL;
      F_ACKDEL: return F_EOF;
      default:  return F_IDLE;
    endcase
  endfunction

  // index of the final bit inside a field
  function automatic int field_last(field_e f, int n_bytes, int eof_len);
    case (f)
      F_BASE:  return BASE_W - 1;
      F_EXTID: return EXT_W - 1;
      F_DLC:   return DLC_W - 1;
      F_DATA:  return n_bytes * 8 - 1;
      F_CRC:   return CRC_W - 1;
      F_EOF:   return eof_len - 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic field_stuffed(field_e f);
    return f inside {F_SOF, F_BASE, F_SRR, F_IDE, F_EXTID, F_RTR, F_R1,
                     F_R0, F_DLC, F_DATA, F_CRC};
  endfunction

  function automatic logic field_crc_covered(field_e f);
    return field_stuffed(f) && (f != F_CRC);
  endfunction
endpackage

// File: rtl/can_crc15.sv
module can_crc15 #(
  parameter int             W    = 15,
  parameter logic [W-1:0]   POLY = 15'h4599
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = bit_i ^ crc_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (en_i)    crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/can_frame_seq.sv
module can_frame_seq
  import can_ser_pkg::*;
#(
  parameter  int MAX_BYTES = 8,
  parameter  int EOF_LEN   = 7,
  localparam int NB_W      = $clog2(MAX_BYTES + 1),
  localparam int CNT_W     = $clog2(MAX_BYTES * 8 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stb_i,
  input  logic             ext_i,
  input  logic [NB_W-1:0]  n_bytes_i,
  output field_e           field_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  field_e           field_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (int'(cnt_q) == field_last(field_q, int'(n_bytes_i), EOF_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= F_IDLE;
      cnt_q   <= '0;
    end else if (field_q == F_IDLE) begin
      if (start_i) begin
        field_q <= F_SOF;
        cnt_q   <= '0;
      end
    end else if (stb_i) begin
      if (at_last) begin
        field_q <= next_field(field_q, ext_i, n_bytes_i == '0);
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign field_o = field_q;
  assign cnt_o   = cnt_q;
  assign last_o  = stb_i && (field_q == F_EOF) && at_last;
endmodule

// File: rtl/can_bit_sel.sv
module can_bit_sel
  import can_ser_pkg::*;
#(
  parameter  int MAX_BYTES = 8,
  localparam int DATA_W    = MAX_BYTES * 8,
  localparam int DIDX_W    = $clog2(DATA_W),
  localparam int CNT_W     = $clog2(MAX_BYTES * 8 + 1)
) (
  input  field_e            field_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              ext_i,
  input  logic              rtr_i,
  input  logic [DLC_W-1:0]  dlc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              bit_o
);
  logic [BASE_W-1:0] base_sh;
  logic [EXT_W-1:0]  ext_sh;
  logic [DLC_W-1:0]  dlc_sh;
  logic [CRC_W-1:0]  crc_sh;
  logic [DIDX_W-1:0] didx;

  always_comb begin
    base_sh = id_i[ID_W-1 -: BASE_W] << cnt_i;
    ext_sh  = id_i[EXT_W-1:0] << cnt_i;
    dlc_sh  = dlc_i << cnt_i;
    crc_sh  = crc_i << cnt_i;
    // byte from upper count bits, MSB first inside the byte
    didx    = {cnt_i[DIDX_W-1:3], ~cnt_i[2:0]};
    case (field_i)
      F_SOF, F_R1, F_R0: bit_o = 1'b0;
      F_BASE:            bit_o = base_sh[BASE_W-1];
      F_IDE:             bit_o = ext_i;
      F_EXTID:           bit_o = ext_sh[EXT_W-1];
      F_RTR:             bit_o = rtr_i;
      F_DLC:             bit_o = dlc_sh[DLC_W-1];
      F_DATA:            bit_o = data_i[didx];
      F_CRC:             bit_o = crc_sh[CRC_W-1];
      default:           bit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/can_frame_serializer.sv
module can_frame_serializer
  import can_ser_pkg::*;
#(
  parameter  int               MAX_BYTES = 8,
  parameter  int               EOF_LEN   = 7,
  parameter  logic [CRC_W-1:0] CRC_POLY  = 15'h4599,
  localparam int               DATA_W    = MAX_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ext_i,
  input  logic              rtr_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DLC_W-1:0]  dlc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_stb_i,
  input  logic              bus_rx_i,
  output logic              bit_o,
  output logic              stuff_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_received_o
);
  localparam int NB_W  = $clog2(MAX_BYTES + 1);
  localparam int CNT_W = $clog2(MAX_BYTES * 8 + 1);

  logic [ID_W-1:0]   id_q;
  logic              ext_q, rtr_q;
  logic [DLC_W-1:0]  dlc_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_q, done_q;
  logic [NB_W-1:0]   n_bytes;
  field_e            field;
  logic [CNT_W-1:0]  cnt;
  logic              last, accept, tx_bit;
  logic [CRC_W-1:0]  crc;

  assign accept = start_i && (field == F_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      ext_q  <= 1'b0;
      rtr_q  <= 1'b0;
      dlc_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      id_q   <= id_i;
      ext_q  <= ext_i;
      rtr_q  <= rtr_i;
      dlc_q  <= dlc_i;
      data_q <= data_i;
    end
  end

  always_comb begin
    if (rtr_q)                         n_bytes = '0;
    else if (int'(dlc_q) >= MAX_BYTES) n_bytes = NB_W'(MAX_BYTES);
    else                               n_bytes = NB_W'(dlc_q);
  end

  can_frame_seq #(.MAX_BYTES(MAX_BYTES), .EOF_LEN(EOF_LEN)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stb_i     (bit_stb_i),
    .ext_i     (ext_q),
    .n_bytes_i (n_bytes),
    .field_o   (field),
    .cnt_o     (cnt),
    .last_o    (last)
  );

  can_bit_sel #(.MAX_BYTES(MAX_BYTES)) i_sel (
    .field_i (field),
    .cnt_i   (cnt),
    .id_i    (id_q),
    .ext_i   (ext_q),
    .rtr_i   (rtr_q),
    .dlc_i   (dlc_q),
    .data_i  (data_q),
    .crc_i   (crc),
    .bit_o   (tx_bit)
  );

  can_crc15 #(.W(CRC_W), .POLY(CRC_POLY)) i_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .en_i    (bit_stb_i && field_crc_covered(field)),
    .bit_i   (tx_bit),
    .crc_o   (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept)                              ack_q <= 1'b0;
      else if (bit_stb_i && field == F_ACK)    ack_q <= !bus_rx_i;
    end
  end

  assign bit_o          = tx_bit;
  assign stuff_en_o     = field_stuffed(field);
  assign busy_o         = (field != F_IDLE);
  assign done_o         = done_q;
  assign ack_received_o = ack_q;
endmodule

// File: rtl/can_frame_serializer_chk.sv
module can_frame_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic bit_stb_i,
  input logic bit_o,
  input logic stuff_en_o,
  input logic busy_o,
  input logic done_o,
  input logic ack_received_o
);
  assert_idle_recessive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> bit_o && !stuff_en_o);

  assert_sof_dominant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !bit_o && stuff_en_o);

  assert_hold_between_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$past(bit_stb_i) |-> $stable(bit_o));

  assert_stuff_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_en_o |-> busy_o);

  assert_ack_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_stb_i) && !$past(start_i) |-> $stable(ack_received_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ends_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o) && $past(bit_stb_i));
endmodule

bind can_frame_serializer can_frame_serializer_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .bit_stb_i      (bit_stb_i),
  .bit_o          (bit_o),
  .stuff_en_o     (stuff_en_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .ack_received_o (ack_received_o)
);

// File: tb/test_can_frame_serializer.sv
module test_can_frame_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, ext, rtr, stb, bus_rx;
  logic [28:0] id;
  logic [3:0]  dlc;
  logic [63:0] data;
  logic        bit_w, stuff_w, busy_w, done_w, ack_w;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        exp_b [200];
  logic        exp_s [200];
  string       exp_t [200];
  int          n_exp;
  logic [14:0] crc_m;

  always #10 clk = ~clk;

  can_frame_serializer i_can_frame_serializer (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .ext_i (ext), .rtr_i (rtr),
    .id_i (id), .dlc_i (dlc), .data_i (data), .bit_stb_i (stb), .bus_rx_i (bus_rx),
    .bit_o (bit_w), .stuff_en_o (stuff_w), .busy_o (busy_w), .done_o (done_w),
    .ack_received_o (ack_w)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic b, input logic st, input logic cov, input string t);
    logic fb;
    exp_b[n_exp] = b;
    exp_s[n_exp] = st;
    exp_t[n_exp] = t;
    n_exp++;
    if (cov) begin
      fb = b ^ crc_m[14];
      crc_m = {crc_m[13:0], 1'b0};
      if (fb) crc_m = crc_m ^ 15'h4599;
    end
  endtask

  task automatic build(input logic e, input logic r, input logic [28:0] idv,
                       input logic [3:0] d, input logic [63:0] dv);
    string t;
    int nb;
    logic [14:0] c;
    n_exp = 0;
    crc_m = '0;
    t = e ? "R5" : "R4";
    push(1'b0, 1'b1, 1'b1, "R2");
    for (int j = 10; j >= 0; j--) push(idv[18+j], 1'b1, 1'b1, t);
    if (e) begin
      push(1'b1, 1'b1, 1'b1, t);
      push(1'b1, 1'b1, 1'b1, t);
      for (int j = 17; j >= 0; j--) push(idv[j], 1'b1, 1'b1, t);
      push(r, 1'b1, 1'b1, t);
      push(1'b0, 1'b1, 1'b1, t);
      push(1'b0, 1'b1, 1'b1, t);
    end else begin
      push(r, 1'b1, 1'b1, t);
      push(1'b0, 1'b1, 1'b1, t);
      push(1'b0, 1'b1, 1'b1, t);
    end
    for (int j = 3; j >= 0; j--) push(d[j], 1'b1, 1'b1, t);
    nb = r ? 0 : ((d > 4'd8) ? 8 : int'(d));
    for (int b = 0; b < nb; b++)
      for (int j = 7; j >= 0; j--) push(dv[8*b+j], 1'b1, 1'b1, "R6");
    c = crc_m;
    for (int j = 14; j >= 0; j--) push(c[j], 1'b1, 1'b0, "R7");
    push(1'b1, 1'b0, 1'b0, "R7");
    for (int j = 0; j < 9; j++) push(1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic run_frame(input int k);
    logic        e, r, ack_on;
    logic [3:0]  d;
    logic [28:0] idv;
    logic [63:0] dv;
    int  bad_b, bad_s, first_b, first_s, early_done, ack_idx;
    e   = k[0];
    r   = k[1];
    d   = 4'(k >> 2);
    idv = 29'(k * 32'h0135_79BD ^ 32'h1A2B_3C4D);
    dv  = 64'h0123_4567_89AB_CDEF ^ {8{8'(k * 29 + 7)}};
    ack_on = k[0] ^ k[3];
    build(e, r, idv, d, dv);
    ack_idx = n_exp - 9;
    bad_b = 0; bad_s = 0; first_b = -1; first_s = -1; early_done = 0;

    ext = e; rtr = r; id = idv; dlc = d; data = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: inputs may change after acceptance
    ext = ~e; rtr = ~r; id = ~idv; dlc = ~d; data = ~dv;
    chk(busy_w == 1'b1, "R2", "busy after start", int'(busy_w), 1);
    chk(ack_w == 1'b0, "R10", "ack cleared on start", int'(ack_w), 0);

    for (int i = 0; i < n_exp; i++) begin
      if (bit_w !== exp_b[i]) begin bad_b++; if (first_b < 0) first_b = i; end
      if (stuff_w !== exp_s[i]) begin bad_s++; if (first_s < 0) first_s = i; end
      if (done_w || !busy_w) early_done++;
      if (i == ack_idx) bus_rx = ack_on ? 1'b0 : 1'b1;
      else              bus_rx = ack_on ? 1'b1 : 1'b0;
      stb = 1'b1;
      if (i == 5) start = 1'b1;  // R2: start while busy is ignored
      @(negedge clk);
      stb = 1'b0;
      start = 1'b0;
      if (i == n_exp - 1) begin
        chk(done_w && !busy_w, "R11", "done after last EOF strobe",
            int'({done_w, busy_w}), 2);
      end
      @(negedge clk);
    end
    bus_rx = 1'b1;
    if (first_b >= 0)
      chk(1'b0, exp_t[first_b], $sformatf("frame %0d bit %0d", k, first_b),
          int'(bit_w), int'(exp_b[first_b]));
    else
      chk(1'b1, "R4", "frame bits", 0, 0);
    chk(bad_s == 0, "R9", $sformatf("frame %0d stuff flag mismatches", k), bad_s, 0);
    chk(early_done == 0, "R3", $sformatf("frame %0d ended early", k), early_done, 0);
    chk(!done_w && bit_w && !stuff_w, "R11", "pulse length and idle bus",
        int'({done_w, bit_w, stuff_w}), 2);
    chk(ack_w == ack_on, "R10", $sformatf("frame %0d ack", k), int'(ack_w), int'(ack_on));
  endtask

  initial begin
    rst_n = 1'b0; start = 0; ext = 0; rtr = 0; stb = 0; bus_rx = 1;
    id = '0; dlc = '0; data = '0;
    repeat (3) @(negedge clk);
    chk(bit_w && !stuff_w && !busy_w && !done_w && !ack_w, "R1", "in reset",
        int'({bit_w, stuff_w, busy_w, done_w, ack_w}), 16);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(bit_w && !stuff_w && !busy_w && !done_w && !ack_w, "R1", "idle after reset",
        int'({bit_w, stuff_w, busy_w, done_w, ack_w}), 16);
    for (int k = 0; k < 64; k++) run_frame(k);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule